// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Byte-Count Stop

This block turns bytes written by a host into asynchronous serial frames on a single output line. Bytes are pushed into a 64-entry queue and taken one at a time by a frame shifter. The frame shape is chosen by configuration inputs: 7 or 8 data bits, an optional bit after the data (either a parity bit or a multiprocessor address/data flag), and one or two stop bits. Each bit is held for 16 pulses of a baud tick input.

A count-limit mode lets the host queue a batch and have the transmitter stop by itself once a programmed number of frames has gone out. An 8-bit count register holds the number of frames minus one, so 0x00 means one frame and 0xFF means 256. After a limited stop, the remaining bytes stay queued until the limit is reloaded by re-enabling the mode, pulsing a restart strobe, or writing the count register.

Top module: `uart_tx_counted`

## Requirements
- R1: The line idles high (1). A frame is a low start bit, then the data bits least significant first, then the optional extra bit, then high stop bits. Each bit lasts exactly 16 tick_i pulses.
- R2: With cfg_len7_i = 1 only bits 6..0 of a byte are sent; with 0 all 8 bits are sent.
- R3: With cfg_extra_i = 1 and cfg_mp_i = 0 a parity bit follows the data. It covers only the data bits sent. With cfg_odd_i = 0 the total count of ones in data plus parity is even; with 1 it is odd.
- R4: With cfg_extra_i = 1 and cfg_mp_i = 1 the bit after the data equals cfg_mpb_i and no parity is sent.
- R5: cfg_stop2_i = 0 gives one stop bit, 1 gives two.
- R6: The queue holds 64 bytes in addition to the byte being shifted. level_o gives the queued count; full_o is 1 at 64 and empty_o is 1 at 0.
- R7: A write while full_o = 1 is dropped and sets overflow_o, which stays 1 until reset.
- R8: The count register resets to 0xFF and is loaded through cnt_we_i/cnt_wdata_i. With cnt_en_i = 1, exactly value+1 frames are sent. Then halted_o = 1, the line stays idle and the remaining bytes stay queued.
- R9: With cnt_en_i = 0 frames are sent as long as the queue holds bytes, and halted_o = 0.
- R10: The frame allowance is reloaded to register value+1 on a 0 to 1 change of cnt_en_i, on a restart_i pulse, and on a register write (which uses the written value).
- R11: After reset: txd_o = 1, level_o = 0, empty_o = 1, full_o = 0, overflow_o = 0, busy_o = 0, halted_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Push strobe |
| wr_data_i | input | 8 | Byte to push |
| cfg_len7_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_extra_i | input | 1 | Send a bit after the data |
| cfg_mp_i | input | 1 | Extra bit is the multiprocessor flag instead of parity |
| cfg_odd_i | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_mpb_i | input | 1 | Multiprocessor flag value |
| cfg_stop2_i | input | 1 | 1: two stop bits |
| cnt_en_i | input | 1 | Count-limit mode enable |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 8 | Count register write value (frames minus one) |
| restart_i | input | 1 | Reload the frame allowance |
| tick_i | input | 1 | Baud tick, 16 per bit |
| txd_o | output | 1 | Serial output line |
| level_o | output | 7 | Bytes queued |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| overflow_o | output | 1 | Sticky dropped-write flag |
| busy_o | output | 1 | A frame is being shifted |
| halted_o | output | 1 | Count limit reached |

## Verification
The bench builds the block with its default parameters: a 64-entry queue, 16 ticks per bit and an 8-bit count register. With these defaults the full and overflow boundary can be reached in one burst of 66 writes while ticks are held off. The count register's 0x00 (one frame) and reset 0xFF ends are both exercised, together with an intermediate limit. A receiver model samples each bit at mid-period and compares whole frames against a queue of expected frames. Any frame sent after a limited stop therefore shows up as unexpected.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic len7;
    logic extra;
    logic mp;
    logic odd;
    logic mpb;
    logic stop2;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          ovf_q;
  logic          push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;
  assign ovf_o   = ovf_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16,
  localparam int TW = $clog2(OS),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  frame_cfg_t    cfg_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          txd_o
);

  tx_state_e     state_q;
  logic [TW-1:0] tick_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shreg_q;
  logic          extra_q;
  frame_cfg_t    cfg_q;

  logic          bit_end, last_stop;
  logic [DW-1:0] mask, masked;
  logic [BW-1:0] last_data;

  assign mask      = cfg_i.len7 ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  assign masked    = data_i & mask;
  assign bit_end   = tick_i && (tick_q == TW'(OS - 1));
  assign last_data = cfg_q.len7 ? BW'(DW - 2) : BW'(DW - 1);
  assign last_stop = !cfg_q.stop2 || (bit_q != '0);
  assign idle_o    = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_STOP) && bit_end && last_stop;

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      ST_EXTRA: txd_o = extra_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      extra_q <= 1'b0;
      cfg_q   <= '0;
    end else if (start_i && idle_o) begin
      state_q <= ST_START;
      tick_q  <= '0;
      bit_q   <= '0;
      shreg_q <= masked;
      cfg_q   <= cfg_i;
      extra_q <= cfg_i.mp ? cfg_i.mpb : ((^masked) ^ cfg_i.odd);
    end else if (tick_i && !idle_o) begin
      tick_q <= bit_end ? '0 : tick_q + 1'b1;
      if (bit_end) begin
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (bit_q == last_data) begin
              state_q <= cfg_q.extra ? ST_EXTRA : ST_STOP;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_EXTRA: begin
            state_q <= ST_STOP;
            bit_q   <= '0;
          end
          ST_STOP: begin
            if (last_stop) state_q <= ST_IDLE;
            else           bit_q   <= bit_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_tx_limit.sv
module uart_tx_limit #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          restart_i,
  input  logic          done_i,
  output logic          allow_o,
  output logic          halted_o
);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   rem_q;
  logic          en_q, reload;
  logic [CW-1:0] src;

  assign reload   = we_i || restart_i || (en_i && !en_q);
  assign src      = we_i ? wdata_i : cnt_q;
  assign allow_o  = !en_i || (rem_q != '0);
  assign halted_o = en_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rem_q <= {1'b1, {CW{1'b0}}};
      en_q  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (we_i) cnt_q <= wdata_i;
      if (reload)                              rem_q <= {1'b0, src} + 1'b1;
      else if (done_i && en_i && rem_q != '0)  rem_q <= rem_q - 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_counted.sv
module uart_tx_counted
  import uart_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int OS    = 16,
  parameter int CW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [DW-1:0]                wr_data_i,
  input  logic                         cfg_len7_i,
  input  logic                         cfg_extra_i,
  input  logic                         cfg_mp_i,
  input  logic                         cfg_odd_i,
  input  logic                         cfg_mpb_i,
  input  logic                         cfg_stop2_i,
  input  logic                         cnt_en_i,
  input  logic                         cnt_we_i,
  input  logic [CW-1:0]                cnt_wdata_i,
  input  logic                         restart_i,
  input  logic                         tick_i,
  output logic                         txd_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         overflow_o,
  output logic                         busy_o,
  output logic                         halted_o
);

  frame_cfg_t    cfg;
  logic [DW-1:0] head;
  logic          idle, done, allow, start;

  assign cfg    = '{len7: cfg_len7_i, extra: cfg_extra_i, mp: cfg_mp_i,
                    odd: cfg_odd_i, mpb: cfg_mpb_i, stop2: cfg_stop2_i};
  assign start  = idle && !empty_o && allow;
  assign busy_o = !idle;

  uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (start),
    .data_o  (head),
    .level_o (level_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (overflow_o)
  );

  uart_tx_frame #(.DW(DW), .OS(OS)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start),
    .data_i  (head),
    .cfg_i   (cfg),
    .idle_o  (idle),
    .done_o  (done),
    .txd_o   (txd_o)
  );

  uart_tx_limit #(.CW(CW)) u_limit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .we_i      (cnt_we_i),
    .wdata_i   (cnt_wdata_i),
    .restart_i (restart_i),
    .done_i    (done),
    .allow_o   (allow),
    .halted_o  (halted_o)
  );

endmodule

// File: rtl/uart_tx_sva.sv
module uart_tx_sva #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          txd_o,
  input logic [LW-1:0] level_o,
  input logic          full_o,
  input logic          overflow_o,
  input logic          busy_o,
  input logic          halted_o
);

  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  p_level_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && full_o |=> overflow_o);

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !wr_en_i |=> level_o == $past(level_o));

endmodule

bind uart_tx_counted uart_tx_sva #(.DEPTH(DEPTH)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .txd_o      (txd_o),
  .level_o    (level_o),
  .full_o     (full_o),
  .overflow_o (overflow_o),
  .busy_o     (busy_o),
  .halted_o   (halted_o)
);

// File: tb/uart_tx_counted_tb.sv
module uart_tx_counted_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       len7 = 0, extra = 0, mp = 0, odd = 0, mpb = 0, stop2 = 0;
  logic       cnt_en = 0, cnt_we = 0, restart = 0, tick = 0;
  logic [7:0] cnt_wdata = '0;
  logic       txd, full, empty, ovf, busy, halted;
  logic [6:0] level;

  int  n_chk = 0, n_fail = 0;
  bit  tick_en = 1'b1;
  int  tper = 2;
  int  phase = 0;
  string cur_tag = "R1";

  typedef struct {
    logic [15:0] pat;
    int          nbits;
    string       tag;
  } frame_t;

  frame_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_tx_counted u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cfg_len7_i(len7), .cfg_extra_i(extra), .cfg_mp_i(mp), .cfg_odd_i(odd),
    .cfg_mpb_i(mpb), .cfg_stop2_i(stop2), .cnt_en_i(cnt_en), .cnt_we_i(cnt_we),
    .cnt_wdata_i(cnt_wdata), .restart_i(restart), .tick_i(tick), .txd_o(txd),
    .level_o(level), .full_o(full), .empty_o(empty), .overflow_o(ovf),
    .busy_o(busy), .halted_o(halted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // tick generator, driven 1 time unit after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      phase = (phase + 1 >= tper) ? 0 : phase + 1;
      tick = tick_en && (phase == 0);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b, input bit will_send);
    frame_t f;
    int nd;
    logic [7:0] m;
    nd = len7 ? 7 : 8;
    m  = len7 ? 8'h7F : 8'hFF;
    f.pat = '0;
    f.nbits = 0;
    f.tag = cur_tag;
    f.pat[f.nbits++] = 1'b0;
    for (int i = 0; i < nd; i++) f.pat[f.nbits++] = b[i];
    if (extra) f.pat[f.nbits++] = mp ? mpb : ((^(b & m)) ^ odd);
    for (int i = 0; i < (stop2 ? 2 : 1); i++) f.pat[f.nbits++] = 1'b1;
    if (will_send) exp_q.push_back(f);
    wr_en = 1'b1;
    wr_data = b;
    step();
    wr_en = 1'b0;
  endtask

  // receiver model / scoreboard monitor
  bit          m_act = 0;
  int          m_tk = 0;
  logic [15:0] m_bits;
  frame_t      m_exp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!m_act) begin
        if (txd === 1'b0) begin
          m_act = 1;
          m_tk = 0;
          m_bits = '0;
          if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected frame after stop", 1, 0);
            m_exp.pat = '0; m_exp.nbits = 10; m_exp.tag = "R8";
          end else begin
            m_exp = exp_q.pop_front();
          end
        end
      end else if (tick) begin
        m_tk++;
        if (m_tk % 16 == 8) begin
          m_bits[m_tk / 16] = txd;
          if (m_tk / 16 == m_exp.nbits - 1) begin
            chk(m_bits == m_exp.pat, {m_exp.tag, " frame bits"},
                int'(m_bits), int'(m_exp.pat));
            m_act = 0;
          end
        end
      end
    end
  end

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || m_act) && t < 20000) begin
      step();
      t++;
    end
    chk(exp_q.size() == 0 && !m_act, {cur_tag, " drain"}, exp_q.size(), 0);
    repeat (400) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk(txd == 1, "R11 txd", txd, 1);
    chk(level == 0, "R11 level", level, 0);
    chk(empty == 1 && full == 0, "R11 empty/full", {empty, full}, 2);
    chk(ovf == 0, "R11 overflow", ovf, 0);
    chk(busy == 0 && halted == 0, "R11 busy/halted", {busy, halted}, 0);

    // R1: 8 data bits, no extra, one stop
    cur_tag = "R1";
    push(8'hA5, 1); push(8'h3C, 1); push(8'h01, 1); push(8'hFF, 1);
    drain();

    // R2/R3/R5: 7 bits, even parity, two stops
    cur_tag = "R2/R3/R5";
    len7 = 1; extra = 1; odd = 0; stop2 = 1;
    push(8'hD3, 1); push(8'h7F, 1);
    drain();

    // R3: 8 bits, odd parity
    cur_tag = "R3";
    len7 = 0; odd = 1; stop2 = 0;
    push(8'h00, 1); push(8'h81, 1);
    drain();

    // R4: multiprocessor flag
    cur_tag = "R4";
    mp = 1; mpb = 1; stop2 = 1;
    push(8'h5A, 1);
    drain();
    mpb = 0;
    push(8'hC3, 1);
    drain();
    mp = 0; extra = 0; stop2 = 0; odd = 0;

    // R8: reset value 0xFF allows many frames
    cur_tag = "R8";
    cnt_en = 1;
    step();
    push(8'h11, 1); push(8'h22, 1); push(8'h33, 1);
    drain();
    chk(halted == 0, "R8 reset count not halted", halted, 0);
    cnt_en = 0;
    step();

    // R8: limit of 3 frames
    cnt_we = 1; cnt_wdata = 8'd2;
    step();
    cnt_we = 0;
    cnt_en = 1;
    step();
    push(8'h41, 1); push(8'h42, 1); push(8'h43, 1); push(8'h44, 0); push(8'h45, 0);
    drain();
    chk(halted == 1, "R8 halted", halted, 1);
    chk(level == 2, "R8 remaining level", level, 2);
    chk(txd == 1 && busy == 0, "R8 line idle", txd, 1);

    // R9: disabling the limit resumes
    cur_tag = "R9";
    exp_q.push_back('{pat: 16'h0, nbits: 0, tag: ""});
    void'(exp_q.pop_back());
    begin
      frame_t f;
      int nb;
      for (int k = 0; k < 2; k++) begin
        logic [7:0] b;
        b = (k == 0) ? 8'h44 : 8'h45;
        nb = 0;
        f.pat = '0;
        f.tag = cur_tag;
        f.pat[nb++] = 1'b0;
        for (int i = 0; i < 8; i++) f.pat[nb++] = b[i];
        f.pat[nb++] = 1'b1;
        f.nbits = nb;
        exp_q.push_back(f);
      end
    end
    cnt_en = 0;
    step();
    drain();
    chk(halted == 0, "R9 not halted", halted, 0);
    chk(level == 0, "R9 drained", level, 0);

    // R10: enable edge reload, count 0 means one frame
    cur_tag = "R10";
    cnt_we = 1; cnt_wdata = 8'd0;
    step();
    cnt_we = 0;
    cnt_en = 1;
    step();
    push(8'h61, 1); push(8'h62, 0);
    drain();
    chk(halted == 1 && level == 1, "R10 one frame then halt", {halted, level}, 129);
    // restart strobe reloads
    exp_q.push_back('{pat: {6'h0, 1'b1, 8'h62, 1'b0}, nbits: 10, tag: "R10 restart"});
    restart = 1;
    step();
    restart = 0;
    drain();
    chk(level == 0, "R10 restart sent", level, 0);
    chk(halted == 1, "R10 halted again", halted, 1);
    // register write reloads
    push(8'h63, 0);
    repeat (50) step();
    chk(level == 1 && txd == 1, "R10 held before write", level, 1);
    exp_q.push_back('{pat: {6'h0, 1'b1, 8'h63, 1'b0}, nbits: 10, tag: "R10 write"});
    cnt_we = 1; cnt_wdata = 8'd0;
    step();
    cnt_we = 0;
    drain();
    chk(level == 0, "R10 write reload", level, 0);
    cnt_en = 0;
    step();

    // R6/R7: fill with ticks stalled
    cur_tag = "R6";
    tick_en = 0;
    step();
    for (int k = 0; k < 66; k++) push(8'(k * 7 + 3), k < 65);
    step();
    chk(level == 64, "R6 level full", level, 64);
    chk(full == 1 && empty == 0, "R6 full flag", {full, empty}, 2);
    chk(ovf == 1, "R7 overflow set", ovf, 1);
    tper = 1;
    tick_en = 1;
    drain();
    chk(empty == 1 && level == 0, "R6 emptied", level, 0);
    chk(ovf == 1, "R7 overflow sticky", ovf, 1);

    finish_run();
  end

endmodule